// File: doc/BRIEF.md
# Five-Stage CIC Decimator for a One-Bit Bitstream

This block turns a one-bit oversampled stream, such as the output of a first-order noise-shaping modulator, into a stream of 16-bit signed samples at one sixty-fourth of the input rate. It contains no multipliers. Five running-sum stages work at the input rate. Five first-difference stages work at the output rate. Together they form a cascaded integrator-comb lowpass filter with a rate change of 64 and a differential delay of one.

Each input bit is qualified by an enable pulse, one per input sample period. A 512 kHz enable gives 8 kHz output samples. The input bit is read as +1 when high and -1 when low. All internal sums are 32 bits wide, which is five times six bits of growth plus two. They wrap in two's complement. The output keeps the upper 16 bits of the last difference stage.

The filter's group delay is 157.5 input samples. A 158-sample shift line is included so that a copy of the input bitstream can be lined up with the filtered output.

Top module: `cic_decim64`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `out_valid`=0, `out_data`=0 and `ref_bit`=0. All sums, difference delays, the rate counter and the shift line are cleared.
- R2: An input bit of 1 enters the first running sum as +1, and an input bit of 0 enters it as -1.
- R3: The five running sums are 32-bit registers that wrap in two's complement. On each enable, stage 0 adds the mapped input. Each later stage adds the value its predecessor held before that edge.
- R4: `out_valid` is a single-cycle pulse. It appears in the cycle right after the 64th, 128th, 192nd, ... enable counted since reset. Between two pulses there are exactly 64 enables.
- R5: At the 64th enable of each group, the difference chain takes the last running sum as it stood before that edge. Each of the five stages subtracts its own input from the previous decimation. `out_data` holds bits [31:16] of the final difference and keeps that value until the next pulse.
- R6: A constant input of 1 settles to a full-scale difference of 64^5 = 2^30, which gives `out_data` = 16'h4000. A constant input of 0 settles to 16'hC000.
- R7: Cycles with `in_en` low change nothing. The output sequence depends only on the ordered sequence of enabled bits, not on the gaps between them.
- R8: After n enables, `ref_bit` equals the bit given at enable number n-158 (counting from 0). It reads 0 while n < 158, and it changes only in a cycle after an enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Input sample enable, one per input sample |
| in_bit | input | 1 | Oversampled input bit (1 = +1, 0 = -1) |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_data | output | 16 | Decimated signed sample, top bits of the final difference |
| ref_bit | output | 1 | Input bit delayed by 158 enables |

## Verification
A filtered sample is due one clock after the edge that takes the 64th enable of its group. The driver computes that sample when it presents the 64th enable and pushes it into a queue. The monitor pops the queue at the falling edge after `out_valid` rises, so every comparison lands on the cycle the result is due. The delayed reference bit is due one edge after each enable. It is compared at the falling edge that follows, before the next bit is driven, against a stored history 158 entries back. Idle gaps between enables move these due points only by the gap length, because the model advances on enables alone.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int unsigned CIC_DECIM     = 64;
    localparam int unsigned CIC_STAGES    = 5;
    localparam int unsigned CIC_OUT_W     = 16;
    localparam int unsigned CIC_ALIGN_LEN = 158;

    // Register growth: stages * log2(rate) plus two guard bits
    function automatic int unsigned acc_width(input int unsigned stages,
                                              input int unsigned decim);
        return stages * $clog2(decim) + 2;
    endfunction

    // 1 -> +1, 0 -> -1 as a two-bit signed code
    function automatic logic signed [1:0] map_bit(input logic b);
        return b ? 2'sb01 : 2'sb11;
    endfunction

    typedef struct packed {
        logic                          valid;
        logic signed [CIC_OUT_W-1:0]   data;
    } cic_sample_t;

endpackage

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr #(
    parameter int unsigned DECIM = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic last
);
    localparam int unsigned CNT_W = $clog2(DECIM);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] cnt;

    assign last = en && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int unsigned STAGES = 5,
    parameter int unsigned ACC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] x,
    output logic [ACC_W-1:0] y
);
    logic [ACC_W-1:0] acc [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [ACC_W-1:0] addend;
        if (s == 0) begin : g_first
            assign addend = x;
        end else begin : g_next
            assign addend = acc[s-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                acc[s] <= '0;
            end else if (en) begin
                acc[s] <= acc[s] + addend;
            end
        end
    end

    assign y = acc[STAGES-1];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
    import cic_pkg::*;
#(
    parameter int unsigned STAGES = 5,
    parameter int unsigned ACC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] x,
    output cic_sample_t      sample
);
    logic [ACC_W-1:0] diff [STAGES+1];
    logic [ACC_W-1:0] dly  [STAGES];

    assign diff[0] = x;

    for (genvar s = 0; s < STAGES; s++) begin : g_comb
        assign diff[s+1] = diff[s] - dly[s];
        always_ff @(posedge clk) begin
            if (rst) begin
                dly[s] <= '0;
            end else if (load) begin
                dly[s] <= diff[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
        end else begin
            sample.valid <= load;
            if (load) begin
                sample.data <= diff[STAGES][ACC_W-1 -: CIC_OUT_W];
            end
        end
    end
endmodule

// File: rtl/cic_align_delay.sv
module cic_align_delay #(
    parameter int unsigned LEN = 158
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [LEN-1:0] line;

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else if (en) begin
            line <= {line[LEN-2:0], d};
        end
    end

    assign q = line[LEN-1];
endmodule

// File: rtl/cic_decim64.sv
module cic_decim64
    import cic_pkg::*;
#(
    parameter int unsigned DECIM     = CIC_DECIM,
    parameter int unsigned STAGES    = CIC_STAGES,
    parameter int unsigned ALIGN_LEN = CIC_ALIGN_LEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_en,
    input  logic                  in_bit,
    output logic                  out_valid,
    output logic [CIC_OUT_W-1:0]  out_data,
    output logic                  ref_bit
);
    localparam int unsigned ACC_W = acc_width(STAGES, DECIM);

    logic signed [1:0] code;
    logic [ACC_W-1:0]  x_ext;
    logic [ACC_W-1:0]  integ_out;
    logic              dec_strobe;
    cic_sample_t       sample;

    assign code  = map_bit(in_bit);
    assign x_ext = {{(ACC_W-2){code[1]}}, code};

    cic_rate_ctr #(.DECIM(DECIM)) u_ctr (
        .clk (clk),
        .rst (rst),
        .en  (in_en),
        .last(dec_strobe)
    );

    cic_integ_chain #(.STAGES(STAGES), .ACC_W(ACC_W)) u_integ (
        .clk(clk),
        .rst(rst),
        .en (in_en),
        .x  (x_ext),
        .y  (integ_out)
    );

    cic_comb_chain #(.STAGES(STAGES), .ACC_W(ACC_W)) u_comb (
        .clk   (clk),
        .rst   (rst),
        .load  (dec_strobe),
        .x     (integ_out),
        .sample(sample)
    );

    cic_align_delay #(.LEN(ALIGN_LEN)) u_align (
        .clk(clk),
        .rst(rst),
        .en (in_en),
        .d  (in_bit),
        .q  (ref_bit)
    );

    assign out_valid = sample.valid;
    assign out_data  = sample.data;
endmodule

// File: rtl/cic_decim64_chk.sv
module cic_decim64_chk #(
    parameter int unsigned DECIM = 64,
    parameter int unsigned OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_en,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             ref_bit
);
    localparam int unsigned SC_W = $clog2(DECIM) + 2;

    logic [SC_W-1:0] en_since;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_since <= '0;
        end else if (out_valid) begin
            en_since <= in_en ? SC_W'(1) : '0;
        end else if (in_en) begin
            en_since <= en_since + 1'b1;
        end
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && !ref_bit));

    // R4
    p_valid_after_en_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_en));

    // R4
    p_valid_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (en_since == SC_W'(DECIM)));

    // R4
    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R8
    p_ref_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(in_en) |-> $stable(ref_bit));
endmodule

bind cic_decim64 cic_decim64_chk #(.DECIM(DECIM), .OUT_W(cic_pkg::CIC_OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_en    (in_en),
    .out_valid(out_valid),
    .out_data (out_data),
    .ref_bit  (ref_bit)
);

// File: tb/tb_cic_decim64.sv
module tb_cic_decim64;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 158;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_en = 1'b0;
    logic        in_bit = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        ref_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_int [5];
    logic [31:0] m_dly [5];
    int          mcnt = 0;
    int          n_en = 0;
    logic [15:0] exp_q [$];
    logic        hist [$];
    logic [15:0] last_out = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cic_decim64 dut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_bit(in_bit),
        .out_valid(out_valid), .out_data(out_data), .ref_bit(ref_bit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 5; k++) begin
            m_int[k] = '0;
            m_dly[k] = '0;
        end
        mcnt = 0;
        n_en = 0;
        hist.delete();
    endtask

    // Reference model: R2 mapping, R3 pipelined sums, R4 grouping, R5 differences
    task automatic model_step(input logic b);
        logic [31:0] c;
        logic [31:0] t;
        if (mcnt == 63) begin
            c = m_int[4];
            for (int k = 0; k < 5; k++) begin
                t = c - m_dly[k];
                m_dly[k] = c;
                c = t;
            end
            exp_q.push_back(c[31:16]);
        end
        for (int k = 4; k > 0; k--) m_int[k] = m_int[k] + m_int[k-1];
        m_int[0] = m_int[0] + (b ? 32'd1 : 32'hFFFF_FFFF);
        mcnt = (mcnt == 63) ? 0 : mcnt + 1;
        hist.push_back(b);
        n_en++;
    endtask

    task automatic check_ref();
        logic e;
        e = (n_en >= DLY) ? hist[n_en - DLY] : 1'b0;
        check(ref_bit === e, "R8 ref_bit delay", {31'd0, ref_bit}, {31'd0, e});
    endtask

    task automatic push_bit(input logic b);
        @(negedge clk);
        check_ref();
        in_en  = 1'b1;
        in_bit = b;
        model_step(b);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            check_ref();
            in_en  = 1'b0;
            in_bit = lfsr[3];
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic wait_drain();
        idle(3);
        check(exp_q.size() == 0, "R4 all expected outputs seen",
              exp_q.size(), 32'd0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        in_en = 1'b0;
        rst   = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid, "R1 out_valid cleared", {31'd0, out_valid}, 32'd0);
        check(out_data == '0, "R1 out_data cleared", {16'd0, out_data}, 32'd0);
        check(!ref_bit, "R1 ref_bit cleared", {31'd0, ref_bit}, 32'd0);
        model_reset();
        rst = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(out_data === e, "R5 sample value", {16'd0, out_data}, {16'd0, e});
                last_out = out_data;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid, "R1 out_valid at reset", {31'd0, out_valid}, 32'd0);
        check(out_data == '0, "R1 out_data at reset", {16'd0, out_data}, 32'd0);
        check(!ref_bit, "R1 ref_bit at reset", {31'd0, ref_bit}, 32'd0);
        rst = 1'b0;

        // R6 / R2: all ones, back to back
        for (int i = 0; i < 30*64; i++) push_bit(1'b1);
        wait_drain();
        check(last_out == 16'h4000, "R6 all-ones steady state", {16'd0, last_out}, 32'h4000);

        // R2 / R6: all zeros
        for (int i = 0; i < 30*64; i++) push_bit(1'b0);
        wait_drain();
        check(last_out == 16'hC000, "R2 all-zeros steady state", {16'd0, last_out}, 32'hC000);

        // R1: reset in mid-run
        for (int i = 0; i < 100; i++) push_bit(i[0]);
        apply_reset();

        // R7: alternating bits with idle gaps
        for (int i = 0; i < 20*64; i++) begin
            push_bit(i[0]);
            if (i % 5 == 2) idle(1 + (i % 3));
        end
        wait_drain();

        // R3 / R7: pseudo-random bits, pseudo-random gaps
        for (int i = 0; i < 40*64; i++) begin
            step_lfsr();
            push_bit(lfsr[0]);
            if (lfsr[5] && lfsr[9]) idle(1 + int'(lfsr[2:1]));
        end
        wait_drain();

        // R3: three ones out of four, back to back
        for (int i = 0; i < 15*64; i++) push_bit(i[1:0] != 2'd3);
        wait_drain();

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule